// File: doc/BRIEF.md
# Floating-Point Deferred Trap Sequencer

This block sequences deferred floating-point traps for a processor core. When the floating-point datapath reports a fault, the sequencer does not interrupt the integer unit at once. It records the address and instruction word of the faulting operation in a single-entry trap queue and marks the queue as occupied. It records the fault class in a 3-bit trap-kind field and moves to a pending mode. The trap reaches the integer unit only when the next floating-point instruction (an arithmetic op, a floating-point load or a floating-point branch) is issued. The mode then becomes exception, and the sequencer sends a one-cycle trap request carrying a trap selector.

While in exception mode, every further floating-point instruction is discarded and marks the trap kind as a sequence error. The trap handler drains the queue with a store request. The store presents the saved address and instruction, empties the queue and returns the sequencer to execute mode. A store request made while the queue is empty is itself a fault with kind sequence error. A parameter chooses between two trap-selector schemes. The narrow scheme always raises a single floating-point trap. The wide scheme separates arithmetic-standard faults from all others.

Top module: `fptrap_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it: `mode` = 0 (execute), `q_full` = 0, `trap_kind` = 0, `iu_trap` = 0, `iu_trap_sel` = 0, `store_ack` = 0, `q_addr`/`q_insn` = 0. `ver_id` always equals the `FPU_VERSION` parameter.
- R2: A fault report (`exc_req`) is accepted in execute mode with the queue empty when no store request or unimplemented report takes precedence. After the next edge, `q_addr`/`q_insn` hold the `pc`/`insn` of that cycle, `q_full` = 1, `trap_kind` = `exc_kind`, and `mode` = 1 (pending).
- R3: A fault report or unimplemented report made in pending or exception mode changes nothing: mode, queue and trap kind keep their values.
- R4: `fp_issue` in pending mode sets `mode` = 2 (exception) after the next edge and raises `iu_trap` for exactly one cycle. The queue and trap kind are unchanged.
- R5: `iu_trap_sel` is 0 whenever `iu_trap` is low. With `WIDE_SEL` = 0 it is 1 during the trap. With `WIDE_SEL` = 1 it is 2 during the trap when `trap_kind` = 1 (arithmetic-standard fault) and 3 for any other kind.
- R6: `fp_issue` in exception mode sets `trap_kind` = 4 (sequence error). The mode stays 2, the queue is not written and no trap is raised.
- R7: `fp_issue` in execute mode has no effect of its own.
- R8: `q_store_req` with `q_full` = 1 pulses `store_ack` for one cycle with `q_addr`/`q_insn` showing the saved entry. After the same edge, `q_full` = 0 and `mode` = 0, and `trap_kind` keeps its value.
- R9: `q_store_req` with `q_full` = 0 is taken as a fault of kind 4. It captures `pc`/`insn`, sets `q_full` = 1 and `mode` = 1.
- R10: When several requests coincide, only one acts. `q_store_req` comes first, then `fp_issue` in pending or exception mode, then a fault report.
- R11: `unimpl_op` raises a fault of kind 3 (unimplemented operation) under the same acceptance rule as R2, and it wins over a simultaneous `exc_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Fault report from the datapath |
| exc_kind | input | 3 | Trap kind of the reported fault |
| unimpl_op | input | 1 | Unimplemented-operation report |
| pc | input | ADDR_W | Address of the current instruction |
| insn | input | INSN_W | Current instruction word |
| fp_issue | input | 1 | A new floating-point instruction is issued |
| q_store_req | input | 1 | Request to store and drain the trap queue |
| iu_trap | output | 1 | One-cycle trap request to the integer unit |
| iu_trap_sel | output | 2 | Trap selector (0 none, 1 generic, 2 arithmetic-standard, 3 other) |
| q_addr | output | ADDR_W | Saved address in the queue entry |
| q_insn | output | INSN_W | Saved instruction in the queue entry |
| store_ack | output | 1 | Queue entry delivered this cycle |
| q_full | output | 1 | Queue-not-empty flag |
| trap_kind | output | 3 | Trap-kind field |
| mode | output | 2 | Sequencer mode (0 execute, 1 pending, 2 exception) |
| ver_id | output | VER_W | Constant version field |

## Verification
Two situations are hard to reach from the ports. One is the sequence error, which needs the block in exception mode and a further instruction issue before the handler drains the queue. The other is a collision of several requests in one cycle while the mode makes more than one of them eligible. Directed sequences walk through fault, pending, trap, repeated issue and store, for each trap kind and for an empty-queue store. A long run then issues biased random requests, with rare mid-run resets, so that coincident requests meet every mode. A behavioural model checks both selector variants on every cycle.

// File: rtl/fptrap_pkg.sv
package fptrap_pkg;

    typedef enum logic [1:0] {
        MODE_EXEC = 2'd0,
        MODE_PEND = 2'd1,
        MODE_EXC  = 2'd2
    } fp_mode_e;

    localparam logic [2:0] KIND_NONE   = 3'd0;
    localparam logic [2:0] KIND_IEEE   = 3'd1;
    localparam logic [2:0] KIND_UNIMPL = 3'd3;
    localparam logic [2:0] KIND_SEQ    = 3'd4;
    localparam logic [2:0] KIND_BADREG = 3'd6;

    typedef enum logic [1:0] {
        IUT_NONE  = 2'd0,
        IUT_FPEXC = 2'd1,
        IUT_IEEE  = 2'd2,
        IUT_OTHER = 2'd3
    } iu_trap_e;

    // one decided action per cycle
    typedef struct packed {
        logic       release_q;
        logic       capture;
        logic       raise_trap;
        logic       seq_err;
        logic [2:0] new_kind;
    } seq_evt_t;

    function automatic iu_trap_e pick_trap(input logic wide, input logic [2:0] kind);
        if (!wide)
            return IUT_FPEXC;
        else if (kind == KIND_IEEE)
            return IUT_IEEE;
        else
            return IUT_OTHER;
    endfunction

endpackage

// File: rtl/fptrap_arbiter.sv
module fptrap_arbiter
    import fptrap_pkg::*;
(
    input  fp_mode_e   mode,
    input  logic       q_full,
    input  logic       q_store_req,
    input  logic       fp_issue,
    input  logic       exc_req,
    input  logic [2:0] exc_kind,
    input  logic       unimpl_op,
    output seq_evt_t   evt
);

    logic fault_any;
    logic fault_ok;
    logic [2:0] fault_kind;

    assign fault_any  = exc_req | unimpl_op;
    assign fault_ok   = fault_any && (mode == MODE_EXEC) && !q_full;
    assign fault_kind = unimpl_op ? KIND_UNIMPL : exc_kind;

    always_comb begin
        evt = '0;
        if (q_store_req) begin
            if (q_full) begin
                evt.release_q = 1'b1;
            end else begin
                evt.capture  = 1'b1;
                evt.new_kind = KIND_SEQ;
            end
        end else if (fp_issue && mode == MODE_PEND) begin
            evt.raise_trap = 1'b1;
        end else if (fp_issue && mode == MODE_EXC) begin
            evt.seq_err = 1'b1;
        end else if (fault_ok) begin
            evt.capture  = 1'b1;
            evt.new_kind = fault_kind;
        end
    end

endmodule

// File: rtl/fptrap_mode_fsm.sv
module fptrap_mode_fsm
    import fptrap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_evt_t   evt,
    output fp_mode_e   mode,
    output logic [2:0] kind
);

    fp_mode_e   mode_q, mode_d;
    logic [2:0] kind_q, kind_d;

    always_comb begin
        mode_d = mode_q;
        kind_d = kind_q;
        unique case (1'b1)
            evt.release_q:  mode_d = MODE_EXEC;
            evt.capture: begin
                mode_d = MODE_PEND;
                kind_d = evt.new_kind;
            end
            evt.raise_trap: mode_d = MODE_EXC;
            evt.seq_err: begin
                mode_d = MODE_EXC;
                kind_d = KIND_SEQ;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_EXEC;
            kind_q <= KIND_NONE;
        end else begin
            mode_q <= mode_d;
            kind_q <= kind_d;
        end
    end

    assign mode = mode_q;
    assign kind = kind_q;

endmodule

// File: rtl/fptrap_queue.sv
module fptrap_queue
    import fptrap_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int INSN_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_evt_t          evt,
    input  logic [ADDR_W-1:0] pc,
    input  logic [INSN_W-1:0] insn,
    output logic              full,
    output logic [ADDR_W-1:0] ent_addr,
    output logic [INSN_W-1:0] ent_insn,
    output logic              ack
);

    logic              full_q;
    logic [ADDR_W-1:0] addr_q;
    logic [INSN_W-1:0] insn_q;
    logic              ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            addr_q <= '0;
            insn_q <= '0;
            ack_q  <= 1'b0;
        end else begin
            ack_q <= evt.release_q;
            if (evt.capture) begin
                full_q <= 1'b1;
                addr_q <= pc;
                insn_q <= insn;
            end else if (evt.release_q) begin
                full_q <= 1'b0;
            end
        end
    end

    assign full     = full_q;
    assign ent_addr = addr_q;
    assign ent_insn = insn_q;
    assign ack      = ack_q;

endmodule

// File: rtl/fptrap_iu_req.sv
module fptrap_iu_req
    import fptrap_pkg::*;
#(
    parameter bit WIDE_SEL = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fire,
    input  logic [2:0] kind,
    output logic       trap,
    output logic [1:0] sel
);

    iu_trap_e sel_d;
    iu_trap_e sel_q;
    logic     trap_q;

    generate
        if (WIDE_SEL) begin : g_wide
            always_comb sel_d = fire ? pick_trap(1'b1, kind) : IUT_NONE;
        end else begin : g_narrow
            always_comb sel_d = fire ? pick_trap(1'b0, kind) : IUT_NONE;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_q <= 1'b0;
            sel_q  <= IUT_NONE;
        end else begin
            trap_q <= fire;
            sel_q  <= sel_d;
        end
    end

    assign trap = trap_q;
    assign sel  = sel_q;

endmodule

// File: rtl/fptrap_seq.sv
module fptrap_seq
    import fptrap_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter int          INSN_W      = 32,
    parameter int          VER_W       = 3,
    parameter logic [VER_W-1:0] FPU_VERSION = 3'd2,
    parameter bit          WIDE_SEL    = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_req,
    input  logic [2:0]        exc_kind,
    input  logic              unimpl_op,
    input  logic [ADDR_W-1:0] pc,
    input  logic [INSN_W-1:0] insn,
    input  logic              fp_issue,
    input  logic              q_store_req,
    output logic              iu_trap,
    output logic [1:0]        iu_trap_sel,
    output logic [ADDR_W-1:0] q_addr,
    output logic [INSN_W-1:0] q_insn,
    output logic              store_ack,
    output logic              q_full,
    output logic [2:0]        trap_kind,
    output logic [1:0]        mode,
    output logic [VER_W-1:0]  ver_id
);

    fp_mode_e   mode_w;
    logic       full_w;
    logic [2:0] kind_w;
    seq_evt_t   evt;

    fptrap_arbiter u_arb (
        .mode        (mode_w),
        .q_full      (full_w),
        .q_store_req (q_store_req),
        .fp_issue    (fp_issue),
        .exc_req     (exc_req),
        .exc_kind    (exc_kind),
        .unimpl_op   (unimpl_op),
        .evt         (evt)
    );

    fptrap_mode_fsm u_fsm (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .mode (mode_w),
        .kind (kind_w)
    );

    fptrap_queue #(.ADDR_W(ADDR_W), .INSN_W(INSN_W)) u_q (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .pc       (pc),
        .insn     (insn),
        .full     (full_w),
        .ent_addr (q_addr),
        .ent_insn (q_insn),
        .ack      (store_ack)
    );

    fptrap_iu_req #(.WIDE_SEL(WIDE_SEL)) u_iu (
        .clk  (clk),
        .rst  (rst),
        .fire (evt.raise_trap),
        .kind (kind_w),
        .trap (iu_trap),
        .sel  (iu_trap_sel)
    );

    assign q_full    = full_w;
    assign trap_kind = kind_w;
    assign mode      = mode_w;
    assign ver_id    = FPU_VERSION;

endmodule

// File: rtl/fptrap_seq_chk.sv
module fptrap_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int INSN_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              exc_req,
    input logic [2:0]        exc_kind,
    input logic              unimpl_op,
    input logic [ADDR_W-1:0] pc,
    input logic [INSN_W-1:0] insn,
    input logic              fp_issue,
    input logic              q_store_req,
    input logic              iu_trap,
    input logic [1:0]        iu_trap_sel,
    input logic [ADDR_W-1:0] q_addr,
    input logic [INSN_W-1:0] q_insn,
    input logic              store_ack,
    input logic              q_full,
    input logic [2:0]        trap_kind,
    input logic [1:0]        mode
);

    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        (!q_store_req && !(fp_issue && mode != 2'd0) && exc_req && !unimpl_op
         && mode == 2'd0 && !q_full)
        |=> (mode == 2'd1 && q_full && q_addr == $past(pc) && q_insn == $past(insn)
             && trap_kind == $past(exc_kind)));

    a_r4_trap_entry: assert property (@(posedge clk) disable iff (rst)
        (!q_store_req && fp_issue && mode == 2'd1) |=> (iu_trap && mode == 2'd2));

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        iu_trap |=> !iu_trap);

    a_r5_sel_idle: assert property (@(posedge clk) disable iff (rst)
        !iu_trap |-> iu_trap_sel == 2'd0);

    a_r5_sel_live: assert property (@(posedge clk) disable iff (rst)
        iu_trap |-> iu_trap_sel != 2'd0);

    a_r6_seq_err: assert property (@(posedge clk) disable iff (rst)
        (!q_store_req && fp_issue && mode == 2'd2)
        |=> (trap_kind == 3'd4 && mode == 2'd2 && $stable(q_addr) && !iu_trap));

    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        (q_store_req && q_full) |=> (store_ack && !q_full && mode == 2'd0));

    a_r9_empty_store: assert property (@(posedge clk) disable iff (rst)
        (q_store_req && !q_full) |=> (q_full && trap_kind == 3'd4 && mode == 2'd1));

endmodule

bind fptrap_seq fptrap_seq_chk #(.ADDR_W(ADDR_W), .INSN_W(INSN_W)) u_chk (
    .clk(clk), .rst(rst), .exc_req(exc_req), .exc_kind(exc_kind), .unimpl_op(unimpl_op),
    .pc(pc), .insn(insn), .fp_issue(fp_issue), .q_store_req(q_store_req),
    .iu_trap(iu_trap), .iu_trap_sel(iu_trap_sel), .q_addr(q_addr), .q_insn(q_insn),
    .store_ack(store_ack), .q_full(q_full), .trap_kind(trap_kind), .mode(mode)
);

// File: tb/fptrap_seq_bench.sv
`timescale 1ns/1ps
module fptrap_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exc_req = 1'b0;
    logic [2:0]  exc_kind = 3'd0;
    logic        unimpl_op = 1'b0;
    logic [31:0] pc = 32'd0;
    logic [31:0] insn = 32'd0;
    logic        fp_issue = 1'b0;
    logic        q_store_req = 1'b0;

    logic        n_trap, w_trap, n_ack, w_ack, n_full, w_full;
    logic [1:0]  n_sel, w_sel, n_mode, w_mode;
    logic [31:0] n_qa, w_qa, n_qi, w_qi;
    logic [2:0]  n_kind, w_kind, n_ver, w_ver;

    always #4 clk = ~clk;

    fptrap_seq u_fptrap_seq (
        .clk(clk), .rst(rst), .exc_req(exc_req), .exc_kind(exc_kind), .unimpl_op(unimpl_op),
        .pc(pc), .insn(insn), .fp_issue(fp_issue), .q_store_req(q_store_req),
        .iu_trap(n_trap), .iu_trap_sel(n_sel), .q_addr(n_qa), .q_insn(n_qi),
        .store_ack(n_ack), .q_full(n_full), .trap_kind(n_kind), .mode(n_mode), .ver_id(n_ver)
    );

    fptrap_seq #(.WIDE_SEL(1'b1), .FPU_VERSION(3'd5)) u_fptrap_seq_wide (
        .clk(clk), .rst(rst), .exc_req(exc_req), .exc_kind(exc_kind), .unimpl_op(unimpl_op),
        .pc(pc), .insn(insn), .fp_issue(fp_issue), .q_store_req(q_store_req),
        .iu_trap(w_trap), .iu_trap_sel(w_sel), .q_addr(w_qa), .q_insn(w_qi),
        .store_ack(w_ack), .q_full(w_full), .trap_kind(w_kind), .mode(w_mode), .ver_id(w_ver)
    );

    // behavioural reference
    int          m_mode = 0;
    bit          m_full = 0;
    bit [2:0]    m_kind = 0;
    bit [31:0]   m_qa = 0, m_qi = 0;
    bit          m_trap = 0, m_ack = 0;
    string       m_tag = "R1";

    always @(posedge clk) begin
        bit fault;
        fault = exc_req || unimpl_op;
        m_trap = 0;
        m_ack  = 0;
        if (rst) begin
            m_mode = 0; m_full = 0; m_kind = 0; m_qa = 0; m_qi = 0;
            m_tag = "R1";
        end else if (q_store_req) begin
            if (m_full) begin
                m_ack = 1; m_full = 0; m_mode = 0; m_tag = "R8";
            end else begin
                m_qa = pc; m_qi = insn; m_full = 1; m_kind = 3'd4; m_mode = 1; m_tag = "R9";
            end
            if (fp_issue || fault) m_tag = "R10";
        end else if (fp_issue && m_mode != 0) begin
            if (m_mode == 1) begin
                m_mode = 2; m_trap = 1; m_tag = "R4";
            end else begin
                m_kind = 3'd4; m_tag = "R6";
            end
            if (fault) m_tag = "R10";
        end else if (fault && m_mode == 0 && !m_full) begin
            m_qa = pc; m_qi = insn; m_full = 1; m_mode = 1;
            m_kind = unimpl_op ? 3'd3 : exc_kind;
            m_tag = unimpl_op ? "R11" : "R2";
            if (fp_issue) m_tag = "R7";
        end else if (fault) begin
            m_tag = "R3";
        end else if (fp_issue) begin
            m_tag = "R7";
        end else begin
            m_tag = "R10";
        end
    end

    int n_cmp = 0;
    int n_mis = 0;
    bit started = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk(m_tag, "mode",  {30'd0, n_mode}, m_mode);
            chk(m_tag, "mode(w)", {30'd0, w_mode}, m_mode);
            chk(m_tag, "q_full", {31'd0, n_full}, {31'd0, m_full});
            chk(m_tag, "q_full(w)", {31'd0, w_full}, {31'd0, m_full});
            chk(m_tag, "trap_kind", {29'd0, n_kind}, {29'd0, m_kind});
            chk(m_tag, "trap_kind(w)", {29'd0, w_kind}, {29'd0, m_kind});
            chk(m_tag, "q_addr", n_qa, m_qa);
            chk(m_tag, "q_insn", w_qi, m_qi);
            chk("R4", "iu_trap", {31'd0, n_trap}, {31'd0, m_trap});
            chk("R4", "iu_trap(w)", {31'd0, w_trap}, {31'd0, m_trap});
            chk("R5", "sel narrow", {30'd0, n_sel}, m_trap ? 32'd1 : 32'd0);
            chk("R5", "sel wide", {30'd0, w_sel},
                m_trap ? ((m_kind == 3'd1) ? 32'd2 : 32'd3) : 32'd0);
            chk("R8", "store_ack", {31'd0, n_ack}, {31'd0, m_ack});
            chk("R8", "store_ack(w)", {31'd0, w_ack}, {31'd0, m_ack});
            chk("R1", "ver_id", {29'd0, n_ver}, 32'd2);
            chk("R1", "ver_id(w)", {29'd0, w_ver}, 32'd5);
        end
    end

    task automatic step(input bit st, input bit is, input bit ex, input bit un,
                        input bit [2:0] k, input bit [31:0] a, input bit [31:0] w);
        @(negedge clk);
        q_store_req = st; fp_issue = is; exc_req = ex; unimpl_op = un;
        exc_kind = k; pc = a; insn = w;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 3'd0, 32'h0, 32'h0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_mis++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        @(posedge clk);
        started = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        idle();
        // R2 then R3 (fault in pending ignored) then R4/R5 trap with kind 1
        step(0, 0, 1, 0, 3'd1, 32'h0000_1000, 32'h81a0_0841);
        step(0, 0, 1, 0, 3'd6, 32'h0000_2000, 32'hdead_beef);
        step(0, 1, 0, 0, 3'd0, 32'h0000_1004, 32'h0);
        idle();
        // R6 repeated issue in exception mode, R3 fault in exception mode
        step(0, 1, 0, 0, 3'd0, 32'h0000_1008, 32'h1111_1111);
        step(0, 0, 0, 1, 3'd0, 32'h0000_100c, 32'h2222_2222);
        // R8 drain
        step(1, 0, 0, 0, 3'd0, 32'h0, 32'h0);
        idle();
        // R7 issue in execute mode
        step(0, 1, 0, 0, 3'd0, 32'h0, 32'h0);
        // fault kind 6, trap: wide selector other
        step(0, 0, 1, 0, 3'd6, 32'h0000_3000, 32'h3333_3333);
        step(0, 1, 0, 0, 3'd0, 32'h0, 32'h0);
        step(1, 0, 0, 0, 3'd0, 32'h0, 32'h0);
        // R9 store with empty queue, then trap kind 4
        step(1, 0, 0, 0, 3'd0, 32'h0000_4000, 32'h4444_4444);
        step(0, 1, 0, 0, 3'd0, 32'h0, 32'h0);
        step(1, 0, 0, 0, 3'd0, 32'h0, 32'h0);
        // R11 unimplemented beats fault report
        step(0, 0, 1, 1, 3'd1, 32'h0000_5000, 32'h5555_5555);
        // R10 all requests together with queue full: store wins
        step(1, 1, 1, 1, 3'd1, 32'h0000_6000, 32'h6666_6666);
        // R10 issue and fault in execute: fault acts
        step(0, 1, 1, 0, 3'd1, 32'h0000_7000, 32'h7777_7777);
        // R10 issue in pending with fault: trap wins
        step(0, 1, 1, 0, 3'd6, 32'h0000_8000, 32'h8888_8888);
        idle();
        // random phase
        for (int i = 0; i < 4000; i++) begin
            bit rr;
            rr = ($urandom_range(0, 499) == 0);
            if (rr) begin
                @(negedge clk); rst = 1;
                idle();
                @(negedge clk); rst = 0;
            end
            step($urandom_range(0, 7) == 0, $urandom_range(0, 2) == 0,
                 $urandom_range(0, 3) == 0, $urandom_range(0, 9) == 0,
                 3'($urandom_range(0, 7)), $urandom, $urandom);
        end
        idle();
        idle();
        @(negedge clk);
        summary();
        $finish;
    end

endmodule